// File: doc/BRIEF.md
# NaN Precision Converter

This combinational unit turns a not-a-number word of one binary floating-point width into a NaN of another width: half, single or double. The source word is first lifted into a canonical form, which is a sign bit plus a 64-bit payload with the source fraction pushed against its top end. The destination word is then rebuilt from that form. Its sign is the canonical sign, its exponent is all ones, and its fraction is the top slice of the canonical payload that fits the destination.

Narrowing can leave an empty fraction, because the low payload bits are lost. That word would read as infinity, so the unit returns the destination's default NaN in its place. A default-NaN mode input forces the default NaN for every conversion. A separate flag reports that the source was a signaling NaN. Conversion of ordinary numbers, rounding, and the wider extended formats are not handled here. A floating-point datapath uses this unit when a NaN operand must cross a precision boundary.

Top module: `nanconv_xlate`

## Requirements
- R1: The source fraction is placed at the top of the 64-bit canonical payload, and the canonical sign is the source format's top bit. For example, half 0x7E55 converted to double gives 0x7FF9540000000000.
- R2: When the result is not a default NaN, the output is the canonical sign, then an all-ones exponent for the destination format, then the top destination-fraction-width bits of the canonical payload.
- R3: When those top payload bits are all zero, the output is the destination default NaN.
- R4: When the default-NaN mode input is 1, the output is always the destination default NaN.
- R5: The invalid flag is 1 exactly when the source is a signaling NaN. A signaling NaN has an all-ones exponent, a fraction MSB of 0, and a nonzero value in the rest of the fraction. The default-NaN mode does not change the flag.
- R6: The default NaNs are 0xFE00 for half, 0xFFC00000 for single and 0xFFF8000000000000 for double.
- R7: The format select codes are 00 for half (5-bit exponent, 10-bit fraction), 01 for single (8, 23) and 10 for double (11, 52). Code 11 is treated as double.
- R8: The input is right-justified, and input bits above the source width are ignored. Output bits above the destination width are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_fmt | input | 2 | Source format select |
| dst_fmt | input | 2 | Destination format select |
| dflt_mode | input | 1 | Force the default NaN on the output |
| nan_in | input | 64 | Source word, right-justified |
| nan_out | output | 64 | Converted word, right-justified, zero-extended |
| invalid | output | 1 | Source was a signaling NaN |

## Verification
The bench sweeps every pair of source and destination codes, including the reserved code, in both modes. It drives quiet NaNs, signaling NaNs, arbitrary words, and signaling NaNs whose only payload bit is the lowest one.

That last pattern goes after narrowing. A unit that skipped the zero-payload fallback would output an infinity. A unit that tested the payload before truncation would keep that infinity instead of a NaN.

Random garbage sits above the source width in every input word. This catches a unit that fails to mask the source and leaks those bits into the sign or the payload.

Signaling NaNs are also driven in default-NaN mode. This exposes a unit that gates the invalid flag with the mode input.

// File: rtl/nanconv_pkg.sv
package nanconv_pkg;

    localparam int WORD_W  = 64;
    localparam int CANON_W = 64;
    localparam int NUM_FMT = 3;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'b00,
        FMT_SINGLE = 2'b01,
        FMT_DOUBLE = 2'b10,
        FMT_RSVD   = 2'b11
    } fmt_e;

    typedef struct packed {
        logic               sign;
        logic               signaling;
        logic [CANON_W-1:0] payload;
    } canon_t;

    function automatic int frac_w(input int idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

    function automatic int exp_w(input int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    // Code 11 is folded onto double.
    function automatic logic [1:0] fmt_index(input fmt_e f);
        return (f == FMT_RSVD) ? 2'd2 : f;
    endfunction

    // Default NaN: sign set, exponent all ones, quiet bit set, rest zero.
    function automatic logic [WORD_W-1:0] default_nan(input int idx);
        logic [WORD_W-1:0] v;
        v = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i >= frac_w(idx) - 1 && i <= frac_w(idx) + exp_w(idx))
                v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/nanconv_unpack.sv
module nanconv_unpack
    import nanconv_pkg::*;
(
    input  fmt_e               src_fmt,
    input  logic [WORD_W-1:0]  word_i,
    output canon_t             canon_o
);

    canon_t cand [NUM_FMT];

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int FW  = frac_w(g);
        localparam int EW  = exp_w(g);
        localparam int TOP = FW + EW;

        logic expo_ones;
        logic is_snan;

        assign expo_ones = &word_i[TOP-1:FW];
        assign is_snan   = expo_ones & ~word_i[FW-1] & (|word_i[FW-2:0]);
        assign cand[g]   = {word_i[TOP], is_snan,
                            word_i[FW-1:0], {(CANON_W-FW){1'b0}}};
    end

    always_comb begin
        case (fmt_index(src_fmt))
            2'd0:    canon_o = cand[0];
            2'd1:    canon_o = cand[1];
            default: canon_o = cand[2];
        endcase
    end

endmodule

// File: rtl/nanconv_pack.sv
module nanconv_pack
    import nanconv_pkg::*;
(
    input  fmt_e                dst_fmt,
    input  logic                dflt_mode,
    input  logic                sign_i,
    input  logic [CANON_W-1:0]  payload_i,
    output logic [WORD_W-1:0]   word_o
);

    logic [WORD_W-1:0] cand [NUM_FMT];
    logic [1:0]        sel;

    assign sel = fmt_index(dst_fmt);

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int FW  = frac_w(g);
        localparam int EW  = exp_w(g);
        localparam int TOP = FW + EW;
        localparam logic [WORD_W-1:0] DFLT = default_nan(g);

        logic [FW-1:0]     trunc;
        logic [WORD_W-1:0] built;

        assign trunc   = FW'(payload_i >> (CANON_W - FW));
        assign built   = WORD_W'({sign_i, {EW{1'b1}}, trunc});
        assign cand[g] = (dflt_mode || trunc == '0) ? DFLT : built;

        always_comb begin
            if (sel == 2'(g)) begin
                a_r2_exp_all_ones: assert (&word_o[TOP-1:FW])
                    else $error("exponent field not all ones");
                a_r3_frac_nonzero: assert (|word_o[FW-1:0])
                    else $error("fraction collapsed to zero");
                if (dflt_mode) begin
                    a_r4_dflt_shape: assert (word_o[TOP] &&
                                             $countones(word_o[FW-1:0]) == 1 &&
                                             word_o[FW-1])
                        else $error("default mode word malformed");
                end
            end
        end

        if (TOP + 1 < WORD_W) begin : g_hi
            always_comb begin
                if (sel == 2'(g)) begin
                    a_r8_upper_zero: assert (word_o[WORD_W-1:TOP+1] == '0)
                        else $error("bits above destination width set");
                end
            end
        end
    end

    always_comb begin
        case (sel)
            2'd0:    word_o = cand[0];
            2'd1:    word_o = cand[1];
            default: word_o = cand[2];
        endcase
    end

endmodule

// File: rtl/nanconv_xlate.sv
module nanconv_xlate
    import nanconv_pkg::*;
(
    input  logic [1:0]  src_fmt,
    input  logic [1:0]  dst_fmt,
    input  logic        dflt_mode,
    input  logic [63:0] nan_in,
    output logic [63:0] nan_out,
    output logic        invalid
);

    canon_t canon;

    nanconv_unpack u_unpack (
        .src_fmt (fmt_e'(src_fmt)),
        .word_i  (nan_in),
        .canon_o (canon)
    );

    nanconv_pack u_pack (
        .dst_fmt   (fmt_e'(dst_fmt)),
        .dflt_mode (dflt_mode),
        .sign_i    (canon.sign),
        .payload_i (canon.payload),
        .word_o    (nan_out)
    );

    assign invalid = canon.signaling;

    // R5: a signaling source has its quiet bit (top of payload) clear.
    always_comb begin
        if (invalid) begin
            a_r5_snan_quiet_clear: assert (!canon.payload[CANON_W-1])
                else $error("invalid raised with quiet bit set");
        end
    end

endmodule

// File: tb/nanconv_xlate_bench.sv
module nanconv_xlate_bench;

    logic        clk = 1'b0;
    logic [1:0]  src_fmt = 2'b00;
    logic [1:0]  dst_fmt = 2'b00;
    logic        dflt_mode = 1'b0;
    logic [63:0] nan_in = '0;
    logic [63:0] nan_out;
    logic        invalid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    always #5 clk = ~clk;

    nanconv_xlate u_nanconv_xlate (
        .src_fmt   (src_fmt),
        .dst_fmt   (dst_fmt),
        .dflt_mode (dflt_mode),
        .nan_in    (nan_in),
        .nan_out   (nan_out),
        .invalid   (invalid)
    );

    function automatic int fw_of(input logic [1:0] f);
        return (f == 2'd0) ? 10 : (f == 2'd1) ? 23 : 52;
    endfunction

    function automatic int ew_of(input logic [1:0] f);
        return (f == 2'd0) ? 5 : (f == 2'd1) ? 8 : 11;
    endfunction

    function automatic logic [63:0] next_rng(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    task automatic model(input logic [1:0] s, input logic [1:0] d,
                         input logic m, input logic [63:0] w,
                         output logic [63:0] eo, output logic ei,
                         output logic [63:0] pay);
        int fs, es, fd, ed;
        logic [63:0] mask, wm, frac, expo, sgn, canon, dflt;
        fs = fw_of(s); es = ew_of(s); fd = fw_of(d); ed = ew_of(d);
        mask  = (fs + es + 1 >= 64) ? '1 : ((64'd1 << (fs + es + 1)) - 1);
        wm    = w & mask;
        frac  = wm & ((64'd1 << fs) - 1);
        expo  = (wm >> fs) & ((64'd1 << es) - 1);
        sgn   = (wm >> (fs + es)) & 64'd1;
        canon = wm << (64 - fs);
        pay   = canon >> (64 - fd);
        ei    = (expo == ((64'd1 << es) - 1)) && (frac[fs-1] == 1'b0) &&
                ((frac & ((64'd1 << (fs - 1)) - 1)) != 0);
        dflt  = ((64'd1 << (ed + 2)) - 1) << (fd - 1);
        eo    = (m || pay == 0) ? dflt
              : (sgn << (ed + fd)) | (((64'd1 << ed) - 1) << fd) | pay;
    endtask

    task automatic apply(input logic [1:0] s, input logic [1:0] d,
                         input logic m, input logic [63:0] w);
        @(negedge clk);
        src_fmt = s; dst_fmt = d; dflt_mode = m; nan_in = w;
        #1;
    endtask

    task automatic cmp_word(input string tag, input logic [63:0] act,
                            input logic [63:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s src=%0d dst=%0d mode=%0d in=%h: actual %h expected %h",
                     tag, src_fmt, dst_fmt, dflt_mode, nan_in, act, exp_v);
        end
    endtask

    task automatic run_one(input logic [1:0] s, input logic [1:0] d,
                           input logic m, input logic [63:0] w);
        logic [63:0] eo, pay;
        logic ei;
        string tag;
        model(s, d, m, w, eo, ei, pay);
        apply(s, d, m, w);
        if (m)                       tag = "R4";
        else if (pay == 0)           tag = "R3";
        else if (s == 3 || d == 3)   tag = "R7";
        else                         tag = "R2";
        cmp_word(tag, nan_out, eo);
        cmp_word("R5", {63'd0, invalid}, {63'd0, ei});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // Initial state: all-zero half input narrows to an empty payload (R3).
        apply(2'd0, 2'd0, 1'b0, 64'd0);
        cmp_word("R3", nan_out, 64'h000000000000FE00);
        cmp_word("R5", {63'd0, invalid}, 64'd0);

        // R1: half 0x7E55 widened to double.
        apply(2'd0, 2'd2, 1'b0, 64'h0000000000007E55);
        cmp_word("R1", nan_out, 64'h7FF9540000000000);

        // R1: sign carried from the source top bit.
        apply(2'd1, 2'd2, 1'b0, 64'h00000000FFC12345);
        cmp_word("R1", nan_out, 64'hFFF82468A0000000);

        // R6: default NaN constants per destination.
        apply(2'd2, 2'd0, 1'b1, 64'h7FF8000000000000);
        cmp_word("R6", nan_out, 64'h000000000000FE00);
        apply(2'd2, 2'd1, 1'b1, 64'h7FF8000000000000);
        cmp_word("R6", nan_out, 64'h00000000FFC00000);
        apply(2'd0, 2'd2, 1'b1, 64'h0000000000007E00);
        cmp_word("R6", nan_out, 64'hFFF8000000000000);

        // R8: garbage above a single-width source is ignored.
        apply(2'd1, 2'd1, 1'b0, 64'hABCD12347FC00001);
        cmp_word("R8", nan_out, 64'h000000007FC00001);

        // R5: signaling double narrowed, default mode on, flag still raised.
        apply(2'd2, 2'd1, 1'b1, 64'h7FF0000000000001);
        cmp_word("R5", nan_out, 64'h00000000FFC00000);
        cmp_word("R5", {63'd0, invalid}, 64'd1);

        // R7: reserved code behaves as double on both sides.
        apply(2'd3, 2'd3, 1'b0, 64'h7FF4000000000ABC);
        cmp_word("R7", nan_out, 64'h7FF4000000000ABC);

        // Sweep over every format pair, both modes, four operand classes.
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 4; d++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int k = 0; k < 48; k++) begin
                        logic [63:0] w;
                        int fs, es;
                        fs = fw_of(2'(s)); es = ew_of(2'(s));
                        rng = next_rng(rng);
                        w = rng;
                        if (k % 4 != 3)
                            w = w | (((64'd1 << es) - 1) << fs);
                        if (k % 4 == 0)
                            w = w | (64'd1 << (fs - 1));
                        if (k % 4 == 1)
                            w = (w & ~(64'd1 << (fs - 1))) | 64'd1;
                        if (k % 4 == 2)
                            w = (w & ~((64'd1 << fs) - 1)) | 64'd1;
                        run_one(2'(s), 2'(d), 1'(m), w);
                    end
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule